// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block keeps track of whether a twisted-pair 10 Mb/s link is usable. It asks the transmitter for a normal link pulse at a fixed interval, and it never stops doing so, whatever the link state or configuration. On the receive side it watches two indications from the receiver. One is a single-cycle mark for each valid link pulse. The other is a level that is high while frame data is arriving. From these it keeps a pass/fail link state, and that state gates the MAC's transmit enable.

A fresh link, or a link that has failed, is only accepted after two link pulses arrive close enough together. Once the link passes, it stays up as long as either kind of receive evidence keeps arriving before the loss timer runs out. When the loss timer expires, the block drops the link. If auto-negotiation is enabled at that moment, it also emits a one-cycle restart request to an external negotiation controller.

A force-pass input overrides monitoring and holds the link up. All intervals are counted in ticks of a clock-enable input `tick_i`, with the counts set by parameters.

Top module: `lnk_integrity_mon`

## Requirements
- R1: `nlp_req_o` is a one-cycle pulse that rises in the cycle after every TX_PERIOD_TICKS-th tick since reset. It does not depend on link state, force-pass or receive inputs.
- R2: While reset is held and after its release (until inputs act), `link_pass_o`=0, `link_fail_o`=1, `tx_en_o`=0, `an_restart_o`=0 and `nlp_req_o`=0.
- R3: In fail state, a received pulse arms pairing. A second pulse arriving while fewer than PAIR_WIN_TICKS ticks have occurred since the arming pulse puts the link in pass from the next cycle.
- R4: In fail state, a lone pulse does not pass the link. If PAIR_WIN_TICKS ticks elapse after the arming pulse, the pairing is dropped, and the next pulse re-arms pairing as a new first pulse. `rx_activity_i` has no effect in fail state.
- R5: In pass state, every cycle with `rx_pulse_i` or `rx_activity_i` high restarts the loss timer. The link stays in pass while the gaps are shorter than LOSS_TICKS ticks.
- R6: In pass state, once LOSS_TICKS ticks pass with no receive event, `link_pass_o` falls and `link_fail_o` rises in the cycle after the expiring tick.
- R7: `an_restart_o` is a one-cycle pulse that rises together with a loss-driven fall of `link_pass_o`. It appears only if `an_enable_i` was high in the expiring cycle, and at no other time.
- R8: While `force_pass_i` is high, `link_pass_o` is 1 in the same cycle and no restart is issued. After it drops, the link remains in pass and the loss timer starts from zero.
- R9: `tx_en_o` equals `tx_en_i` AND `link_pass_o`, and `link_fail_o` is the inverse of `link_pass_o`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| force_pass_i | input | 1 | Bypass monitoring and hold link in pass |
| an_enable_i | input | 1 | Auto-negotiation enabled; allows restart requests |
| rx_pulse_i | input | 1 | One cycle per received valid link pulse |
| rx_activity_i | input | 1 | High while receive data activity is present |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| nlp_req_o | output | 1 | Request to send one normal link pulse |
| link_pass_o | output | 1 | Link integrity state is pass |
| link_fail_o | output | 1 | Link integrity state is fail |
| tx_en_o | output | 1 | Transmit enable gated by link state |
| an_restart_o | output | 1 | One-cycle auto-negotiation restart request |

## Verification
The hardest situations to reach from the ports are the ones where a pulse arrives right at a boundary. One case is a second link pulse arriving on or next to the tick that closes the pairing window. Another is a receive event landing in the same cycle as the tick that would expire the loss timer. In both cases a one-cycle shift flips the outcome. Directed sequences place pulses a few ticks inside and outside each window. A long random phase then varies pulse and activity densities so that events repeatedly fall on both sides of those boundaries, while a behavioural model decides every cycle which outcome is correct.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
  typedef enum logic {LNK_FAIL = 1'b0, LNK_PASS = 1'b1} lnk_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lnk_pulse_sched.sv
`timescale 1ns/1ps
module lnk_pulse_sched #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic req_o
);
  localparam int unsigned W = lnk_pkg::cnt_width(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;
  logic         req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/lnk_loss_timer.sv
`timescale 1ns/1ps
module lnk_loss_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic event_i,
  output logic expire_o
);
  localparam int unsigned W = lnk_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // event has priority over a coincident tick
  assign expire_o = run_i & tick_i & ~event_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || event_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_pair_qual.sv
`timescale 1ns/1ps
module lnk_pair_qual #(
  parameter int unsigned WINDOW = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  input  logic pulse_i,
  output logic qualify_o
);
  localparam int unsigned W = lnk_pkg::cnt_width(WINDOW);
  localparam logic [W-1:0] LAST = W'(WINDOW - 1);

  logic         armed_q;
  logic [W-1:0] win_q;

  assign qualify_o = ~clear_i & armed_q & pulse_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (pulse_i) begin
      // second pulse qualifies, first one arms
      armed_q <= ~armed_q;
      win_q   <= '0;
    end else if (tick_i && armed_q) begin
      if (win_q == LAST) begin
        armed_q <= 1'b0;
        win_q   <= '0;
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lnk_integrity_mon.sv
`timescale 1ns/1ps
module lnk_integrity_mon #(
  parameter int unsigned TX_PERIOD_TICKS = 16,
  parameter int unsigned LOSS_TICKS      = 100,
  parameter int unsigned PAIR_WIN_TICKS  = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic force_pass_i,
  input  logic an_enable_i,
  input  logic rx_pulse_i,
  input  logic rx_activity_i,
  input  logic tx_en_i,
  output logic nlp_req_o,
  output logic link_pass_o,
  output logic link_fail_o,
  output logic tx_en_o,
  output logic an_restart_o
);
  import lnk_pkg::*;

  lnk_state_e state_q, state_d;
  logic       restart_q;
  logic       run, clear_qual, expire, qualify, rx_event;

  assign rx_event   = rx_pulse_i | rx_activity_i;
  assign run        = (state_q == LNK_PASS) & ~force_pass_i;
  assign clear_qual = (state_q == LNK_PASS) | force_pass_i;

  lnk_pulse_sched #(.PERIOD(TX_PERIOD_TICKS)) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .req_o  (nlp_req_o)
  );

  lnk_loss_timer #(.LIMIT(LOSS_TICKS)) u_loss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .event_i  (rx_event),
    .expire_o (expire)
  );

  lnk_pair_qual #(.WINDOW(PAIR_WIN_TICKS)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clear_i   (clear_qual),
    .pulse_i   (rx_pulse_i),
    .qualify_o (qualify)
  );

  always_comb begin
    state_d = state_q;
    if (force_pass_i)                           state_d = LNK_PASS;
    else if (state_q == LNK_PASS && expire)     state_d = LNK_FAIL;
    else if (state_q == LNK_FAIL && qualify)    state_d = LNK_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LNK_FAIL;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= expire & an_enable_i;
    end
  end

  // force acts in the same cycle
  assign link_pass_o  = (state_q == LNK_PASS) | force_pass_i;
  assign link_fail_o  = ~link_pass_o;
  assign tx_en_o      = tx_en_i & link_pass_o;
  assign an_restart_o = restart_q;
endmodule

// File: rtl/lnk_integrity_chk.sv
`timescale 1ns/1ps
module lnk_integrity_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic force_pass_i,
  input logic an_enable_i,
  input logic rx_pulse_i,
  input logic rx_activity_i,
  input logic nlp_req_o,
  input logic link_pass_o,
  input logic an_restart_o
);
  // R1
  nlp_req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nlp_req_o |=> !nlp_req_o);

  // R1
  nlp_req_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nlp_req_o |-> $past(tick_i));

  // R3
  pass_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(link_pass_o) && !force_pass_i) |-> $past(rx_pulse_i));

  // R6
  pass_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_pass_o) |-> $past(tick_i && !rx_pulse_i && !rx_activity_i && !force_pass_i));

  // R7
  restart_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |=> !an_restart_o);

  // R7
  restart_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |-> ($past(link_pass_o) && $past(an_enable_i) && (!link_pass_o || force_pass_i)));

  // R8
  force_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_pass_i |=> !an_restart_o);

  // R8
  force_drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_pass_i) |-> link_pass_o);
endmodule

bind lnk_integrity_mon lnk_integrity_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .force_pass_i  (force_pass_i),
  .an_enable_i   (an_enable_i),
  .rx_pulse_i    (rx_pulse_i),
  .rx_activity_i (rx_activity_i),
  .nlp_req_o     (nlp_req_o),
  .link_pass_o   (link_pass_o),
  .an_restart_o  (an_restart_o)
);

// File: tb/lnk_integrity_mon_tb_top.sv
`timescale 1ns/1ps
module lnk_integrity_mon_tb_top;
  localparam int TXP  = 8;
  localparam int LOSS = 20;
  localparam int WIN  = 6;
  localparam int TDIV = 3; // cycles per tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, force_p = 1'b0, an_en = 1'b0;
  logic rx_pulse = 1'b0, rx_act = 1'b0, tx_en_in = 1'b0;
  logic nlp_req, link_pass, link_fail, tx_en_out, an_restart;

  int checks = 0, fails = 0, restarts = 0, reqs = 0, cyc = 0;

  // behavioural reference state
  int m_txc = 0, m_loss = 0, m_win = 0;
  bit m_req = 0, m_pass = 0, m_armed = 0, m_restart = 0;

  always #10 clk = ~clk;

  lnk_integrity_mon #(.TX_PERIOD_TICKS(TXP), .LOSS_TICKS(LOSS), .PAIR_WIN_TICKS(WIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .force_pass_i(force_p),
    .an_enable_i(an_en), .rx_pulse_i(rx_pulse), .rx_activity_i(rx_act),
    .tx_en_i(tx_en_in), .nlp_req_o(nlp_req), .link_pass_o(link_pass),
    .link_fail_o(link_fail), .tx_en_o(tx_en_out), .an_restart_o(an_restart)
  );

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    tick <= ((cyc % TDIV) == TDIV - 1);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txc = 0; m_loss = 0; m_win = 0;
      m_req = 0; m_pass = 0; m_armed = 0; m_restart = 0;
    end else begin
      m_req = 0;
      if (tick) begin
        if (m_txc == TXP - 1) begin m_txc = 0; m_req = 1; end
        else m_txc++;
      end
      m_restart = 0;
      if (force_p) begin
        m_pass = 1; m_loss = 0; m_armed = 0; m_win = 0;
      end else if (m_pass) begin
        if (rx_pulse || rx_act) m_loss = 0;
        else if (tick) begin
          if (m_loss == LOSS - 1) begin m_pass = 0; m_loss = 0; m_restart = an_en; end
          else m_loss++;
        end
      end else begin
        if (rx_pulse) begin
          if (m_armed) begin m_pass = 1; m_armed = 0; end
          else begin m_armed = 1; m_win = 0; end
        end else if (tick && m_armed) begin
          if (m_win == WIN - 1) m_armed = 0;
          else m_win++;
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always begin
    @(negedge clk);
    #5;
    if (an_restart) restarts++;
    if (nlp_req) reqs++;
    check(nlp_req, m_req, "R1 nlp_req_o");
    check(link_pass, m_pass | force_p, "R3/R5/R6 link_pass_o");
    check(link_fail, ~(m_pass | force_p), "R9 link_fail_o");
    check(tx_en_out, tx_en_in & (m_pass | force_p), "R9 tx_en_o");
    check(an_restart, m_restart, "R7 an_restart_o");
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); rx_pulse = 1'b1;
    @(negedge clk); rx_pulse = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int r0, q0;
    tx_en_in = 1'b1;
    #35;
    // R2 reset state
    check(link_pass, 1'b0, "R2 reset link_pass_o");
    check(link_fail, 1'b1, "R2 reset link_fail_o");
    check(tx_en_out, 1'b0, "R2 reset tx_en_o");
    check(an_restart, 1'b0, "R2 reset an_restart_o");
    check(nlp_req, 1'b0, "R2 reset nlp_req_o");
    step(2); rst_n = 1'b1;
    step(1); #5;
    check(link_pass, 1'b0, "R2 after release link_pass_o");

    // R1 request cadence
    q0 = reqs; step(TDIV * TXP * 5); #5;
    check(reqs - q0 == 5, 1'b1, "R1 five requests per window");

    // R4 lone pulse and activity in fail
    pulse(); step(TDIV * WIN + 6); #5;
    check(link_pass, 1'b0, "R4 lone pulse");
    @(negedge clk); rx_act = 1'b1; step(5); rx_act = 1'b0; step(1); #5;
    check(link_pass, 1'b0, "R4 activity in fail");

    // R3 pair within window
    pulse(); step(TDIV * 2); pulse(); #5;
    check(link_pass, 1'b1, "R3 pair passes");

    // R5 keep alive
    for (int k = 0; k < 10; k++) begin
      step(TDIV * (LOSS / 2));
      @(negedge clk);
      if (k % 2 == 0) rx_act = 1'b1; else rx_pulse = 1'b1;
      @(negedge clk); rx_act = 1'b0; rx_pulse = 1'b0;
    end
    #5; check(link_pass, 1'b1, "R5 kept alive");

    // R6/R7 loss with auto-negotiation
    an_en = 1'b1; r0 = restarts;
    step(TDIV * LOSS + 10); #5;
    check(link_fail, 1'b1, "R6 loss fails link");
    check(restarts - r0 == 1, 1'b1, "R7 one restart");

    // R4 late second pulse re-arms
    pulse(); step(TDIV * (WIN + 2)); pulse(); step(3); #5;
    check(link_pass, 1'b0, "R4 late pulse no pass");
    pulse(); #5;
    check(link_pass, 1'b1, "R4 re-armed pair passes");

    // R7 no restart without auto-negotiation
    an_en = 1'b0; r0 = restarts;
    step(TDIV * LOSS + 10); #5;
    check(link_pass, 1'b0, "R6 loss no an");
    check(restarts == r0, 1'b1, "R7 no restart when disabled");

    // R8 force pass
    @(negedge clk); force_p = 1'b1; #5;
    check(link_pass, 1'b1, "R8 force immediate");
    check(tx_en_out, 1'b1, "R9 tx gate under force");
    an_en = 1'b1; r0 = restarts;
    step(TDIV * LOSS * 2); #5;
    check(link_pass, 1'b1, "R8 held under force");
    check(restarts == r0, 1'b1, "R8 no restart under force");
    @(negedge clk); force_p = 1'b0;
    step(TDIV * (LOSS - 2)); #5;
    check(link_pass, 1'b1, "R8 pass kept after drop");
    step(TDIV * 4); #5;
    check(link_pass, 1'b0, "R8 timer from zero after drop");
    check(restarts - r0 == 1, 1'b1, "R7 restart after drop");
    @(negedge clk); tx_en_in = 1'b0; #5;
    check(tx_en_out, 1'b0, "R9 tx gate off");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rx_pulse = ($urandom_range(0, 99) < ((i / 1000) % 2 ? 4 : 15));
      rx_act   = ($urandom_range(0, 99) < ((i / 1500) % 2 ? 1 : 6));
      tx_en_in = $urandom_range(0, 1);
      an_en    = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 399) == 0) force_p = ~force_p;
    end
    @(negedge clk);
    rx_pulse = 1'b0; rx_act = 1'b0; force_p = 1'b0;
    step(4);
    summary();
    $finish;
  end
endmodule